// File: doc/BRIEF.md
# Layer Configuration Shadow Bank with Frame-Boundary Commit

This block holds the per-layer configuration words of a display compositor in two copies. Software reaches only the staging (shadow) copy, through single-cycle read and write strobes on a 32-bit, word-addressed register port. The working (live) copy feeds the downstream pixel logic on a flat output bus and changes only on a frame-boundary strobe, so a half-written layer setup never reaches the screen.

A transfer from shadow to live happens at a vblank strobe when a load has been requested or when automatic loading is on. The load-request bit in the control word clears itself once the transfer is done, so software polls that bit (or watches the pending output) before it stages the next set of changes.

Top module: `layer_cfg_shadow_bank`

## Requirements
- R1: After reset, commit_pending_o is 0, every live word is 0, every layer word reads 0, and the control word at address 0 reads 2 (bit 1, autoload-disable, set; bit 0, load-request, clear).
- R2: Layer word i (i = layer*REGS_PER_LAYER + index) sits at word address 4+i; a write stores it in the shadow copy, a read strobe returns the shadow value on rdata_o one cycle later, and the live copy does not change on the write.
- R3: A control write with bit 0 set raises the load request, visible on commit_pending_o and as bit 0 of the control word from the next cycle; it stays set until a transfer, and a control write with bit 0 clear does not clear it.
- R4: A vblank_i strobe while a load is pending copies every shadow word to live_cfg_o (word i at bits 32*i+31 down to 32*i) in the next cycle and clears the load request at the same edge.
- R5: With autoload disabled and no load pending, a vblank_i strobe leaves the live copy unchanged, and without a vblank_i strobe the live copy never changes.
- R6: With autoload enabled (control bit 1 written 0), every vblank_i strobe copies shadow to live.
- R7: A layer write in the same cycle as a transfer sends the pre-write value to the live copy and keeps the new value in the shadow copy only.
- R8: A load-request write in the same cycle as a vblank_i strobe does not cause a transfer by itself in that cycle; the new request stays pending for the next strobe.
- R9: Bit 0 and bit 1 of the control word both take effect when written in the same write.
- R10: Addresses that map to neither the control word nor a layer word read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| vblank_i | input | 1 | Frame-boundary strobe, one cycle per frame |
| commit_pending_o | output | 1 | Load request still outstanding |
| live_cfg_o | output | NUM_LAYERS*REGS_PER_LAYER*32 | Live configuration words, word i in slice i |

## Verification
Every result here is one register away from its cause: read data, the pending flag and the live bus all change at the clock edge that samples the strobe, so each is due one cycle after the stimulus. The bench drives strobes on the falling edge, holds them for one cycle, and compares on the following falling edge; read expectations go into a queue that a monitor drains exactly one cycle after it sees the read strobe, while live-bus and pending checks follow each task's return. Same-cycle collisions of vblank with layer writes and with load requests are driven in a single cycle to pin the ordering of R7 and R8.

// File: rtl/lcsb_pkg.sv
package lcsb_pkg;
  localparam int WORD_W     = 32;
  localparam int CTRL_ADDR  = 0;
  localparam int CFG_BASE   = 4;
  localparam int LOAD_BIT   = 0;
  localparam int NOAUTO_BIT = 1;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/lcsb_decode.sv
module lcsb_decode
  import lcsb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 16,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ctrl_hit_o,
  output logic              cfg_hit_o,
  output logic [IDX_W-1:0]  cfg_idx_o
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off        = addr_i - ADDR_W'(CFG_BASE);
    ctrl_hit_o = (addr_i == ADDR_W'(CTRL_ADDR));
    cfg_hit_o  = (addr_i >= ADDR_W'(CFG_BASE)) && (off < ADDR_W'(NUM_WORDS));
    cfg_idx_o  = off[IDX_W-1:0];
  end
endmodule

// File: rtl/lcsb_commit_ctrl.sv
module lcsb_commit_ctrl
  import lcsb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctrl_wr_i,
  input  word_t wdata_i,
  input  logic  vblank_i,
  output logic  load_req_o,
  output logic  autoload_dis_o,
  output logic  copy_o
);
  logic load_req_q, autoload_dis_q, set_req;

  // decision uses registered state: a same-cycle request waits for the next strobe
  assign set_req = ctrl_wr_i && wdata_i[LOAD_BIT];
  assign copy_o  = vblank_i && (load_req_q || !autoload_dis_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_req_q     <= 1'b0;
      autoload_dis_q <= 1'b1;
    end else begin
      load_req_q <= set_req || (load_req_q && !copy_o);
      if (ctrl_wr_i) autoload_dis_q <= wdata_i[NOAUTO_BIT];
    end
  end

  assign load_req_o     = load_req_q;
  assign autoload_dis_o = autoload_dis_q;
endmodule

// File: rtl/lcsb_reg_bank.sv
module lcsb_reg_bank
  import lcsb_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  word_t             wdata_i,
  input  logic              copy_i,
  output logic [FLAT_W-1:0] shadow_o,
  output logic [FLAT_W-1:0] live_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    word_t shadow_q, live_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        live_q   <= '0;
      end else begin
        if (wr_i && (idx_i == IDX_W'(g))) shadow_q <= wdata_i;
        if (copy_i) live_q <= shadow_q;
      end
    end

    assign shadow_o[g*WORD_W +: WORD_W] = shadow_q;
    assign live_o[g*WORD_W +: WORD_W]   = live_q;
  end
endmodule

// File: rtl/layer_cfg_shadow_bank.sv
module layer_cfg_shadow_bank
  import lcsb_pkg::*;
#(
  parameter int NUM_LAYERS     = 4,
  parameter int REGS_PER_LAYER = 4,
  parameter int ADDR_W         = 8
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         wr_en_i,
  input  logic                                         rd_en_i,
  input  logic [ADDR_W-1:0]                            addr_i,
  input  logic [WORD_W-1:0]                            wdata_i,
  output logic [WORD_W-1:0]                            rdata_o,
  input  logic                                         vblank_i,
  output logic                                         commit_pending_o,
  output logic [NUM_LAYERS*REGS_PER_LAYER*WORD_W-1:0]  live_cfg_o
);
  localparam int NUM_WORDS = NUM_LAYERS * REGS_PER_LAYER;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int FLAT_W    = NUM_WORDS * WORD_W;

  logic              ctrl_hit, cfg_hit, copy, load_req, autoload_dis;
  logic [IDX_W-1:0]  cfg_idx;
  logic [FLAT_W-1:0] shadow_flat;
  word_t             rd_word, rdata_q;

  lcsb_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .addr_i     (addr_i),
    .ctrl_hit_o (ctrl_hit),
    .cfg_hit_o  (cfg_hit),
    .cfg_idx_o  (cfg_idx)
  );

  lcsb_commit_ctrl u_commit (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_wr_i      (wr_en_i && ctrl_hit),
    .wdata_i        (wdata_i),
    .vblank_i       (vblank_i),
    .load_req_o     (load_req),
    .autoload_dis_o (autoload_dis),
    .copy_o         (copy)
  );

  lcsb_reg_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && cfg_hit),
    .idx_i    (cfg_idx),
    .wdata_i  (wdata_i),
    .copy_i   (copy),
    .shadow_o (shadow_flat),
    .live_o   (live_cfg_o)
  );

  always_comb begin
    rd_word = '0;
    if (ctrl_hit) begin
      rd_word[LOAD_BIT]   = load_req;
      rd_word[NOAUTO_BIT] = autoload_dis;
    end else if (cfg_hit) begin
      rd_word = shadow_flat[cfg_idx*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end

  assign rdata_o          = rdata_q;
  assign commit_pending_o = load_req;
endmodule

// File: rtl/lcsb_checker.sv
module lcsb_checker
  import lcsb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FLAT_W = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic              vblank_i,
  input logic              commit_pending_o,
  input logic [FLAT_W-1:0] live_cfg_o,
  input logic [FLAT_W-1:0] shadow_flat,
  input logic              autoload_dis
);
  logic ctrl_set;
  assign ctrl_set = wr_en_i && (addr_i == ADDR_W'(CTRL_ADDR)) && wdata_i[LOAD_BIT];

  assert_req_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_set |=> commit_pending_o);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_pending_o && !vblank_i |=> commit_pending_o);

  assert_req_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i && commit_pending_o && !ctrl_set |=> !commit_pending_o);

  assert_commit_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i && commit_pending_o |=> live_cfg_o == $past(shadow_flat));

  assert_autoload_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i && !autoload_dis |=> live_cfg_o == $past(shadow_flat));

  assert_live_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vblank_i && (commit_pending_o || !autoload_dis)) |=> $stable(live_cfg_o));
endmodule

bind layer_cfg_shadow_bank lcsb_checker #(.ADDR_W(ADDR_W), .FLAT_W(FLAT_W)) u_lcsb_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .wr_en_i          (wr_en_i),
  .addr_i           (addr_i),
  .wdata_i          (wdata_i),
  .vblank_i         (vblank_i),
  .commit_pending_o (commit_pending_o),
  .live_cfg_o       (live_cfg_o),
  .shadow_flat      (shadow_flat),
  .autoload_dis     (autoload_dis)
);

// File: tb/layer_cfg_shadow_bank_bench.sv
module layer_cfg_shadow_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4, RPL = 4, AW = 8;
  localparam int NW = NL * RPL;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0, vblank_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic commit_pending_o;
  logic [NW*32-1:0] live_cfg_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  layer_cfg_shadow_bank #(.NUM_LAYERS(NL), .REGS_PER_LAYER(RPL), .ADDR_W(AW)) u_layer_cfg_shadow_bank (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .vblank_i, .commit_pending_o, .live_cfg_o
  );

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string req_q[$];
  logic rd_seen = 1'b0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] live_word(input int i);
    return live_cfg_o[i*32 +: 32];
  endfunction

  task automatic check_live(input int i, input logic [31:0] exp, input string req);
    check(live_word(i) == exp, req, live_word(i), exp);
  endtask

  task automatic check_pend(input logic exp, input string req);
    check(commit_pending_o == exp, req, {31'b0, commit_pending_o}, {31'b0, exp});
  endtask

  // monitor: pops one expected read value the cycle after each read strobe
  always @(posedge clk_i) rd_seen <= rd_en_i;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string r = req_q.pop_front();
      check(rdata_o == e, r, rdata_o, e);
    end
  end

  task automatic do_write(input int a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_read(input int a, input logic [31:0] exp, input string req);
    exp_q.push_back(exp); req_q.push_back(req);
    rd_en_i = 1'b1; addr_i = AW'(a);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic pulse_vblank();
    vblank_i = 1'b1;
    @(negedge clk_i);
    vblank_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check_pend(1'b0, "R1");
    check(live_cfg_o == '0, "R1", live_word(0), 32'h0);
    do_read(0, 32'h2, "R1");
    do_read(4, 32'h0, "R1");

    // R2 shadow write / read, live untouched
    do_write(4, 32'hA5A5_0001);
    do_write(9, 32'h1234_5678);
    do_read(4, 32'hA5A5_0001, "R2");
    do_read(9, 32'h1234_5678, "R2");
    check_live(0, 32'h0, "R2");
    check_live(5, 32'h0, "R2");

    // R5 vblank with autoload disabled and nothing pending
    pulse_vblank();
    check_live(0, 32'h0, "R5");
    check_pend(1'b0, "R5");

    // R3 load request set, held, not cleared by a 0 write
    do_write(0, 32'h3);
    check_pend(1'b1, "R3");
    check_live(0, 32'h0, "R3");
    do_read(0, 32'h3, "R3");
    repeat (3) @(negedge clk_i);
    check_pend(1'b1, "R3");
    do_write(0, 32'h2);
    check_pend(1'b1, "R3");
    check_live(5, 32'h0, "R3");

    // R4 transfer at vblank
    pulse_vblank();
    check_live(0, 32'hA5A5_0001, "R4");
    check_live(5, 32'h1234_5678, "R4");
    check_pend(1'b0, "R4");
    do_read(0, 32'h2, "R4");

    // R7 layer write colliding with the transfer
    do_write(4, 32'hBBBB_0002);
    do_write(0, 32'h3);
    wr_en_i = 1'b1; addr_i = AW'(4); wdata_i = 32'hDDDD_0003; vblank_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; vblank_i = 1'b0;
    check_live(0, 32'hBBBB_0002, "R7");
    check_pend(1'b0, "R7");
    do_read(4, 32'hDDDD_0003, "R7");
    do_write(0, 32'h3);
    pulse_vblank();
    check_live(0, 32'hDDDD_0003, "R7");

    // R8 load request colliding with vblank
    do_write(6, 32'hEEEE_0004);
    wr_en_i = 1'b1; addr_i = AW'(0); wdata_i = 32'h3; vblank_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; vblank_i = 1'b0;
    check_pend(1'b1, "R8");
    check_live(2, 32'h0, "R8");
    pulse_vblank();
    check_live(2, 32'hEEEE_0004, "R8");
    check_pend(1'b0, "R8");

    // R9 request and autoload enable in one write
    do_write(0, 32'h1);
    check_pend(1'b1, "R9");
    do_read(0, 32'h1, "R9");
    pulse_vblank();
    check_pend(1'b0, "R9");
    do_read(0, 32'h0, "R9");

    // R6 autoload copies at every vblank
    do_write(NW + 3, 32'hF000_0001);
    pulse_vblank();
    check_live(NW - 1, 32'hF000_0001, "R6");
    check_pend(1'b0, "R6");
    do_write(NW + 3, 32'hF000_0002);
    pulse_vblank();
    check_live(NW - 1, 32'hF000_0002, "R6");
    do_write(NW + 3, 32'hF000_0003);
    repeat (2) @(negedge clk_i);
    check_live(NW - 1, 32'hF000_0002, "R6");
    pulse_vblank();
    check_live(NW - 1, 32'hF000_0003, "R6");

    // R10 unmapped addresses
    do_write(2, 32'hFFFF_FFFF);
    do_write(NW + 4, 32'hFFFF_FFFF);
    do_write(200, 32'hFFFF_FFFF);
    do_read(2, 32'h0, "R10");
    do_read(NW + 4, 32'h0, "R10");
    do_read(0, 32'h0, "R10");
    do_read(NW + 3, 32'hF000_0003, "R10");
    check_pend(1'b0, "R10");
    pulse_vblank();
    check_live(NW - 1, 32'hF000_0003, "R10");

    repeat (2) @(negedge clk_i);
    check(exp_q.size() == 0, "scoreboard drain", exp_q.size(), 0);
    finish_run();
  end
endmodule